// File: doc/BRIEF.md
# Accumulator Execute Unit with Operand Register Bank

This block is the execute stage of a small 16-bit accumulator machine. It holds one accumulator, one index register, a carry flag and a bank of 512 16-bit operand registers. It also contains a word-addressed local data memory. Each cycle, an upstream decoder may present one operation: a 4-bit opcode, a 2-bit addressing mode, a 9-bit register number and a 16-bit immediate. The addressing mode selects the operand. The arithmetic or logic result goes back to the accumulator. The store and index-load operations write elsewhere instead.

An operand can come from four places: the immediate field; a bank entry named directly; a bank entry named by the index register; or a local-memory word whose address is held in a named bank entry. Only the low `MEM_AW` bits of that address are used. The default model has 256 words, and a full 64K-word memory needs `MEM_AW = 16`. Fetch, branching and channel I/O belong to other blocks. A branch unit reads the accumulator-zero and carry outputs.

Top module: `acc_exec_unit`

## Requirements
- R1: A synchronous active-high `rst` clears the accumulator, the index register and carry. The bank and the memory are not cleared.
- R2: Opcode 0 (add) sets acc = acc + operand, and carry takes the carry out. Opcode 1 (subtract) sets acc = acc - operand, and carry is set exactly when acc < operand (a borrow).
- R3: Opcode 2 (increment) and opcode 3 (decrement) ignore the operand and add or subtract 1. Increment sets carry on wrap from 0xFFFF. Decrement sets carry on a borrow from 0x0000.
- R4: Opcode 4 (AND) sets acc = acc & operand, and opcode 5 (move) sets acc = operand. Both leave carry unchanged.
- R5: Opcode 6 shifts acc left by one and opcode 7 shifts it right by one. Both shift in zero and put the bit shifted out (bit 15 or bit 0) into carry. Both ignore the operand.
- R6: The mode selects the operand. Mode 0 is the immediate. Mode 1 is bank[reg_num]. Mode 2 is bank[index[8:0]]. Mode 3 is mem[bank[reg_num]].
- R7: In mode 3, only the low MEM_AW bits (8 by default) of the pointer register address the memory.
- R8: Opcode 8 (store) writes acc to the location chosen by modes 1 to 3. Acc and carry stay unchanged. A store in mode 0 writes nothing.
- R9: Opcode 9 (index load) loads the operand into the index register. Acc and carry stay unchanged.
- R10: When `op_valid` is low, or the opcode is 10 to 15, acc, index, carry, the bank and the memory all keep their values.
- R11: `acc_zero` is high exactly when the current accumulator value is zero.
- R12: An operation presented before a rising edge is visible on `acc` and `carry` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Opcode |
| mode | input | 2 | Addressing mode |
| reg_num | input | 9 | Operand register number |
| imm | input | 16 | Immediate operand |
| acc | output | 16 | Accumulator |
| carry | output | 1 | Carry / borrow flag |
| acc_zero | output | 1 | High when the accumulator is zero |

## Verification
The assertions assume that reset has been applied and that `op` and `mode` are always driven to known values. They also assume that any bank entry or memory word read as an operand was written at some earlier point. The stimulus meets these assumptions in three ways:
- It first fills every bank entry and every memory word through store operations.
- It then draws opcodes and modes only from their full defined ranges. Opcodes 10 to 15 are exercised as no-ops.
- It keeps `op_valid` low between directed sequences so that the idle assertion is exercised.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_INC   = 4'd2,
    OP_DEC   = 4'd3,
    OP_AND   = 4'd4,
    OP_MOV   = 4'd5,
    OP_SHL   = 4'd6,
    OP_SHR   = 4'd7,
    OP_STORE = 4'd8,
    OP_LDX   = 4'd9
  } op_e;

  typedef enum logic [1:0] {
    AM_IMM    = 2'd0,
    AM_DIRECT = 2'd1,
    AM_INDEX  = 2'd2,
    AM_MEMIND = 2'd3
  } mode_e;

  typedef struct packed {
    logic wr_acc;
    logic wr_carry;
    logic wr_idx;
    logic wr_store;
  } alu_ctl_t;

endpackage

// File: rtl/acc_word_ram.sv
module acc_word_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/acc_opsel.sv
module acc_opsel
  import acc_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RAW    = 9,
  parameter int MEM_AW = 8
) (
  input  mode_e           mode,
  input  logic [RAW-1:0]  reg_num,
  input  logic [DW-1:0]   idx,
  input  logic [DW-1:0]   imm,
  input  logic [DW-1:0]   bank_rdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [RAW-1:0]  bank_addr,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DW-1:0]   operand
);

  assign bank_addr = (mode == AM_INDEX) ? idx[RAW-1:0] : reg_num;
  assign mem_addr  = bank_rdata[MEM_AW-1:0];

  always_comb begin
    unique case (mode)
      AM_IMM:    operand = imm;
      AM_DIRECT: operand = bank_rdata;
      AM_INDEX:  operand = bank_rdata;
      default:   operand = mem_rdata;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  logic          carry_in,
  output logic [DW-1:0] result,
  output logic          carry_out,
  output alu_ctl_t      ctl
);

  logic [DW:0] sum_w;
  logic [DW:0] diff_w;
  logic [DW:0] inc_w;

  assign sum_w  = {1'b0, acc} + {1'b0, opnd};
  assign diff_w = {1'b0, acc} - {1'b0, opnd};
  assign inc_w  = {1'b0, acc} + {{DW{1'b0}}, 1'b1};

  always_comb begin
    result    = acc;
    carry_out = carry_in;
    ctl       = '0;
    case (op)
      OP_ADD: begin
        result = sum_w[DW-1:0];  carry_out = sum_w[DW];
        ctl.wr_acc = 1'b1;       ctl.wr_carry = 1'b1;
      end
      OP_SUB: begin
        result = diff_w[DW-1:0]; carry_out = diff_w[DW];
        ctl.wr_acc = 1'b1;       ctl.wr_carry = 1'b1;
      end
      OP_INC: begin
        result = inc_w[DW-1:0];  carry_out = inc_w[DW];
        ctl.wr_acc = 1'b1;       ctl.wr_carry = 1'b1;
      end
      OP_DEC: begin
        result = acc - {{(DW-1){1'b0}}, 1'b1};
        carry_out = (acc == '0);
        ctl.wr_acc = 1'b1;       ctl.wr_carry = 1'b1;
      end
      OP_AND: begin
        result = acc & opnd;     ctl.wr_acc = 1'b1;
      end
      OP_MOV: begin
        result = opnd;           ctl.wr_acc = 1'b1;
      end
      OP_SHL: begin
        result = {acc[DW-2:0], 1'b0}; carry_out = acc[DW-1];
        ctl.wr_acc = 1'b1;       ctl.wr_carry = 1'b1;
      end
      OP_SHR: begin
        result = {1'b0, acc[DW-1:1]}; carry_out = acc[0];
        ctl.wr_acc = 1'b1;       ctl.wr_carry = 1'b1;
      end
      OP_STORE: ctl.wr_store = 1'b1;
      OP_LDX:   ctl.wr_idx   = 1'b1;
      default:  ctl = '0;
    endcase
  end

  // R2: a borrow on subtract means the minuend was the smaller value
  always_comb begin
    if (op == OP_SUB)
      a_r2_sub_borrow: assert (carry_out == (acc < opnd));
  end

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
  import acc_pkg::*;
#(
  parameter int DW     = 16,
  parameter int NREGS  = 512,
  parameter int MEM_AW = 8,
  localparam int RAW   = $clog2(NREGS),
  localparam int MEM_WORDS = 1 << MEM_AW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [3:0]     op,
  input  logic [1:0]     mode,
  input  logic [RAW-1:0] reg_num,
  input  logic [DW-1:0]  imm,
  output logic [DW-1:0]  acc,
  output logic           carry,
  output logic           acc_zero
);

  logic [DW-1:0]     idx_q;
  logic [DW-1:0]     bank_rdata;
  logic [DW-1:0]     mem_rdata;
  logic [RAW-1:0]    bank_addr;
  logic [MEM_AW-1:0] mem_addr;
  logic [DW-1:0]     operand;
  logic [DW-1:0]     alu_res;
  logic              alu_carry;
  alu_ctl_t          ctl;
  mode_e             mode_s;
  logic              bank_we;
  logic              mem_we;

  assign mode_s = mode_e'(mode);

  acc_opsel #(.DW(DW), .RAW(RAW), .MEM_AW(MEM_AW)) u_opsel (
    .mode      (mode_s),
    .reg_num   (reg_num),
    .idx       (idx_q),
    .imm       (imm),
    .bank_rdata(bank_rdata),
    .mem_rdata (mem_rdata),
    .bank_addr (bank_addr),
    .mem_addr  (mem_addr),
    .operand   (operand)
  );

  acc_word_ram #(.DW(DW), .DEPTH(NREGS)) u_bank (
    .clk  (clk),
    .we   (bank_we),
    .waddr(bank_addr),
    .wdata(acc),
    .raddr(bank_addr),
    .rdata(bank_rdata)
  );

  acc_word_ram #(.DW(DW), .DEPTH(MEM_WORDS)) u_lmem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_addr),
    .wdata(acc),
    .raddr(mem_addr),
    .rdata(mem_rdata)
  );

  acc_alu #(.DW(DW)) u_alu (
    .op       (op),
    .acc      (acc),
    .opnd     (operand),
    .carry_in (carry),
    .result   (alu_res),
    .carry_out(alu_carry),
    .ctl      (ctl)
  );

  assign bank_we = op_valid && ctl.wr_store &&
                   (mode_s == AM_DIRECT || mode_s == AM_INDEX);
  assign mem_we  = op_valid && ctl.wr_store && (mode_s == AM_MEMIND);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      idx_q <= '0;
      carry <= 1'b0;
    end else if (op_valid) begin
      if (ctl.wr_acc)   acc   <= alu_res;
      if (ctl.wr_carry) carry <= alu_carry;
      if (ctl.wr_idx)   idx_q <= operand;
    end
  end

  assign acc_zero = ~|acc;

  // R8: store leaves accumulator and carry alone
  a_r8_store_holds: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_STORE) |=> ($stable(acc) && $stable(carry)));

  // R4: AND and move keep carry
  a_r4_logic_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op == OP_AND || op == OP_MOV)) |=> $stable(carry));

  // R10: idle or undefined opcode changes nothing
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op > 4'd9) |=> ($stable(acc) && $stable(carry) && $stable(idx_q)));

  // R3: increment advances accumulator by one
  a_r3_inc_adds_one: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_INC) |=> (acc == $past(acc) + 16'd1));

  // R5: left shift moves top bit into carry
  a_r5_shl_carry: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_SHL) |=> (carry == $past(acc[DW-1]) && acc[0] == 1'b0));

  // R9: index load leaves accumulator alone
  a_r9_ldx_holds_acc: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == OP_LDX) |=> $stable(acc));

endmodule

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;
  import acc_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op;
  logic [1:0]  mode;
  logic [8:0]  reg_num;
  logic [15:0] imm;
  logic [15:0] acc;
  logic        carry;
  logic        acc_zero;

  int n_checks = 0;
  int n_fails  = 0;

  logic [15:0] m_reg [512];
  logic [15:0] m_mem [256];
  logic [15:0] m_acc;
  logic [15:0] m_idx;
  logic        m_c;

  always #5 clk = ~clk;

  acc_exec_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op(op), .mode(mode),
    .reg_num(reg_num), .imm(imm), .acc(acc), .carry(carry), .acc_zero(acc_zero)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4, 4'd5: return "R4";
      4'd6, 4'd7: return "R5";
      4'd8:       return "R8";
      4'd9:       return "R9";
      default:    return "R10";
    endcase
  endfunction

  function automatic logic [15:0] opnd_of(input logic [1:0] md, input logic [8:0] rn,
                                          input logic [15:0] im);
    case (md)
      2'd0:    return im;
      2'd1:    return m_reg[rn];
      2'd2:    return m_reg[m_idx[8:0]];
      default: return m_mem[m_reg[rn][7:0]];
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [1:0] md, input logic [8:0] rn,
                       input logic [15:0] im);
    logic [15:0] v;
    logic [16:0] w;
    v = opnd_of(md, rn, im);
    case (o)
      4'd0: begin w = {1'b0, m_acc} + {1'b0, v}; m_acc = w[15:0]; m_c = w[16]; end
      4'd1: begin m_c = (m_acc < v); m_acc = m_acc - v; end
      4'd2: begin m_c = (m_acc == 16'hFFFF); m_acc = m_acc + 16'd1; end
      4'd3: begin m_c = (m_acc == 16'h0000); m_acc = m_acc - 16'd1; end
      4'd4: m_acc = m_acc & v;
      4'd5: m_acc = v;
      4'd6: begin m_c = m_acc[15]; m_acc = m_acc << 1; end
      4'd7: begin m_c = m_acc[0];  m_acc = m_acc >> 1; end
      4'd8: case (md)
              2'd1: m_reg[rn] = m_acc;
              2'd2: m_reg[m_idx[8:0]] = m_acc;
              2'd3: m_mem[m_reg[rn][7:0]] = m_acc;
              default: ;
            endcase
      4'd9: m_idx = v;
      default: ;
    endcase
  endtask

  // Drive one operation, update the model, and compare once the edge has passed (R12).
  task automatic exec(input logic [3:0] o, input logic [1:0] md, input logic [8:0] rn,
                      input logic [15:0] im);
    string t;
    t = tag_of(o);
    @(negedge clk);
    op_valid = 1'b1; op = o; mode = md; reg_num = rn; imm = im;
    model(o, md, rn, im);
    @(posedge clk);
    #2;
    op_valid = 1'b0;
    chk(acc == m_acc, {t, " R6 R12 acc"}, acc, m_acc);
    chk(carry == m_c, {t, " carry"}, carry, m_c);
    chk(acc_zero == (m_acc == 16'h0), "R11 acc_zero", acc_zero, m_acc == 16'h0);
  endtask

  initial begin
    #2_000_000;
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; op_valid = 1'b0; op = '0; mode = '0; reg_num = '0; imm = '0;
    m_acc = '0; m_idx = '0; m_c = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;
    // R1 reset state
    chk(acc == 16'h0, "R1 acc after reset", acc, 0);
    chk(carry == 1'b0, "R1 carry after reset", carry, 0);
    chk(acc_zero == 1'b1, "R1 R11 zero after reset", acc_zero, 1);

    // Fill the bank (R8 direct store)
    for (int r = 0; r < 512; r++) begin
      exec(4'd5, 2'd0, '0, 16'($urandom));
      exec(4'd8, 2'd1, 9'(r), '0);
    end
    // Fill memory through pointer register 0 (R7 R8)
    for (int a = 0; a < 256; a++) begin
      exec(4'd5, 2'd0, '0, 16'(a) | 16'hAB00);
      exec(4'd8, 2'd1, 9'd0, '0);
      exec(4'd5, 2'd0, '0, 16'($urandom));
      exec(4'd8, 2'd3, 9'd0, '0);
    end

    // Directed: add wrap, subtract borrow, inc/dec corners
    exec(4'd5, 2'd0, '0, 16'hFFFF);
    exec(4'd0, 2'd0, '0, 16'h0001);
    chk(acc == 16'h0 && carry == 1'b1, "R2 add wrap", {acc, 7'b0, carry}, 32'h1);
    exec(4'd1, 2'd0, '0, 16'h0001);
    chk(acc == 16'hFFFF && carry == 1'b1, "R2 sub borrow", acc, 16'hFFFF);
    exec(4'd2, 2'd0, '0, 16'h1234);
    chk(acc == 16'h0 && carry == 1'b1, "R3 inc wrap", acc, 0);
    exec(4'd3, 2'd0, '0, 16'h0);
    chk(acc == 16'hFFFF && carry == 1'b1, "R3 dec borrow", acc, 16'hFFFF);
    exec(4'd7, 2'd0, '0, 16'h0);
    chk(acc == 16'h7FFF && carry == 1'b1, "R5 shr", acc, 16'h7FFF);

    // Directed: store in immediate mode writes nothing (R8)
    exec(4'd5, 2'd0, '0, 16'hAAAA);
    exec(4'd8, 2'd1, 9'd5, '0);
    exec(4'd5, 2'd0, '0, 16'h5555);
    exec(4'd8, 2'd0, 9'd5, 16'h0000);
    exec(4'd5, 2'd1, 9'd5, '0);
    chk(acc == 16'hAAAA, "R8 imm store ignored", acc, 16'hAAAA);

    // Directed: index load and index-mode read (R9 R6)
    exec(4'd9, 2'd0, '0, 16'hFE05);
    exec(4'd5, 2'd2, 9'd0, '0);
    chk(acc == 16'hAAAA, "R9 R6 index low 9 bits", acc, 16'hAAAA);

    // Directed: idle cycles change nothing (R10)
    repeat (4) @(posedge clk);
    #2;
    chk(acc == 16'hAAAA, "R10 idle holds", acc, 16'hAAAA);
    exec(4'd12, 2'd1, 9'd5, 16'h1111);
    exec(4'd5, 2'd1, 9'd5, '0);
    chk(acc == 16'hAAAA, "R10 undefined opcode", acc, 16'hAAAA);

    // Random stream
    for (int k = 0; k < 4000; k++) begin
      exec(4'($urandom % 16), 2'($urandom % 4), 9'($urandom), 16'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule